// File: doc/BRIEF.md
# Environment Configuration CSR Unit

This block holds the two environment configuration control registers of a core, one owned by machine mode and one by supervisor mode. Software reaches them through a single-cycle CSR port: an address, write data, a write strobe and a flag telling the block whether the hart runs with 32-bit or 64-bit registers. Every write is legalized, so a field that is absent reads back as zero. Read data is combinational from the current address.

Only three bits are live. The machine register carries the supervisor timer-compare enable and the I/O-fence-implies-memory bit. The supervisor register carries only its own I/O-fence bit. Two build parameters decide whether the timer-compare enable and the fence bits can be set at all. The live bits also drive dedicated outputs that the rest of the core decodes.

The cache-block and page-memory-type fields exist in the layout but are hard-wired to zero. Privilege checks belong to the caller. The block has no state machine: its only state is the three enable flops, and each flop is loaded by a legalized write or kept.

Top module: `envcfg_unit`

## Requirements
- R1: After reset, reads of 0x30A, 0x31A and 0x10A return zero, and all three enable outputs are 0.
- R2: In 64-bit mode a read of 0x30A returns the legalized 64-bit value. Only bit 63 (timer-compare enable) and bit 0 (fence bit) can be nonzero. Bits 62..1 always read zero.
- R3: When the timer-compare parameter is 0, bit 63 of the machine register stays 0 whatever is written to it.
- R4: When the fence-writable parameter is 0, bit 0 of both registers stays 0 whatever is written to it.
- R5: The supervisor register at 0x10A keeps only bit 0. Every other bit reads zero, including bits 63 and 62.
- R6: In 32-bit mode, 0x30A reads and writes the low 32 bits of the machine register, and the read result is zero-extended. 0x31A reads and writes the upper 32 bits, so write-data bit 31 maps to register bit 63. A write to one half leaves the other half unchanged.
- R7: In 64-bit mode, 0x31A reads zero and writes to it have no effect.
- R8: Output tce_o follows machine register bit 63, m_fiom_o follows machine bit 0, and s_fiom_o follows supervisor bit 0. Each output changes in the cycle after the write.
- R9: Any other address reads zero, and a write to it changes no register.
- R10: With csr_we_i low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 64 | Write data (upper half unused in 32-bit mode) |
| csr_we_i | input | 1 | Write strobe |
| xlen32_i | input | 1 | 1 selects 32-bit register width |
| csr_rdata_o | output | 64 | Read data for csr_addr_i |
| tce_o | output | 1 | Supervisor timer-compare enable |
| m_fiom_o | output | 1 | Machine I/O-fence-implies-memory |
| s_fiom_o | output | 1 | Supervisor I/O-fence-implies-memory |

## Verification
The bench builds two copies of the block side by side. One copy has both the timer-compare extension and the writable fence bit. The other copy has neither. The same writes go to both copies, so every all-ones pattern shows in the same cycle whether a field takes the written value or is forced to zero by the build. Switching xlen32_i between writes exercises the split upper-half address and the 64-bit view of the same flops.

// File: rtl/envcfg_pkg.sv
package envcfg_pkg;
    localparam int CFG_W  = 64;
    localparam int HALF_W = CFG_W / 2;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] A_MCFG   = 12'h30A;
    localparam logic [ADDR_W-1:0] A_MCFG_H = 12'h31A;
    localparam logic [ADDR_W-1:0] A_SCFG   = 12'h10A;

    localparam int B_TCE  = 63;
    localparam int B_FIOM = 0;

    typedef struct packed {
        logic tce;
        logic m_fiom;
        logic s_fiom;
    } cfg_bits_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_MLO,
        SEL_MHI,
        SEL_SUP
    } cfg_sel_e;
endpackage

// File: rtl/envcfg_decode.sv
module envcfg_decode
    import envcfg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              xlen32_i,
    output cfg_sel_e          sel_o
);
    always_comb begin
        sel_o = SEL_NONE;
        unique case (addr_i)
            A_MCFG:   sel_o = SEL_MLO;
            A_MCFG_H: sel_o = xlen32_i ? SEL_MHI : SEL_NONE;
            A_SCFG:   sel_o = SEL_SUP;
            default:  sel_o = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/envcfg_legalize.sv
module envcfg_legalize
    import envcfg_pkg::*;
#(
    parameter bit HAS_TC   = 1'b1,
    parameter bit FIOM_WR  = 1'b1
) (
    input  cfg_sel_e         sel_i,
    input  logic             we_i,
    input  logic             xlen32_i,
    input  logic [CFG_W-1:0] wdata_i,
    input  cfg_bits_t        cur_i,
    output cfg_bits_t        nxt_i
);
    logic tc_wbit;
    logic fiom_wbit;
    logic [CFG_W-1:0] merged;

    always_comb begin
        merged = {cur_i.tce, {(CFG_W-2){1'b0}}, cur_i.m_fiom};
        if (sel_i == SEL_MHI)
            merged[CFG_W-1:HALF_W] = wdata_i[HALF_W-1:0];
        else if (xlen32_i)
            merged[HALF_W-1:0] = wdata_i[HALF_W-1:0];
        else
            merged = wdata_i;
    end

    generate
        if (HAS_TC) begin : g_tc
            assign tc_wbit = merged[B_TCE];
        end else begin : g_no_tc
            assign tc_wbit = 1'b0;
        end
        if (FIOM_WR) begin : g_fiom
            assign fiom_wbit = merged[B_FIOM];
        end else begin : g_no_fiom
            assign fiom_wbit = 1'b0;
        end
    endgenerate

    always_comb begin
        nxt_i = cur_i;
        if (we_i) begin
            unique case (sel_i)
                SEL_MLO, SEL_MHI: begin
                    nxt_i.tce    = tc_wbit;
                    nxt_i.m_fiom = fiom_wbit;
                end
                SEL_SUP: nxt_i.s_fiom = FIOM_WR ? wdata_i[B_FIOM] : 1'b0;
                default: nxt_i = cur_i;
            endcase
        end
    end
endmodule

// File: rtl/envcfg_rmux.sv
module envcfg_rmux
    import envcfg_pkg::*;
(
    input  cfg_sel_e         sel_i,
    input  logic             xlen32_i,
    input  cfg_bits_t        cur_i,
    output logic [CFG_W-1:0] rdata_o
);
    logic [CFG_W-1:0] mfull;

    assign mfull = {cur_i.tce, {(CFG_W-2){1'b0}}, cur_i.m_fiom};

    always_comb begin
        rdata_o = '0;
        unique case (sel_i)
            SEL_MLO: rdata_o = xlen32_i ? {{HALF_W{1'b0}}, mfull[HALF_W-1:0]} : mfull;
            SEL_MHI: rdata_o = {{HALF_W{1'b0}}, mfull[CFG_W-1:HALF_W]};
            SEL_SUP: rdata_o = {{(CFG_W-1){1'b0}}, cur_i.s_fiom};
            default: rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/envcfg_unit.sv
module envcfg_unit
    import envcfg_pkg::*;
#(
    parameter bit HAS_TC  = 1'b1,
    parameter bit FIOM_WR = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] csr_addr_i,
    input  logic [CFG_W-1:0]  csr_wdata_i,
    input  logic              csr_we_i,
    input  logic              xlen32_i,
    output logic [CFG_W-1:0]  csr_rdata_o,
    output logic              tce_o,
    output logic              m_fiom_o,
    output logic              s_fiom_o
);
    cfg_sel_e  sel;
    cfg_bits_t cfg_q;
    cfg_bits_t cfg_d;

    envcfg_decode u_dec (
        .addr_i   (csr_addr_i),
        .xlen32_i (xlen32_i),
        .sel_o    (sel)
    );

    envcfg_legalize #(.HAS_TC(HAS_TC), .FIOM_WR(FIOM_WR)) u_leg (
        .sel_i    (sel),
        .we_i     (csr_we_i),
        .xlen32_i (xlen32_i),
        .wdata_i  (csr_wdata_i),
        .cur_i    (cfg_q),
        .nxt_i    (cfg_d)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    envcfg_rmux u_rd (
        .sel_i    (sel),
        .xlen32_i (xlen32_i),
        .cur_i    (cfg_q),
        .rdata_o  (csr_rdata_o)
    );

    assign tce_o    = cfg_q.tce;
    assign m_fiom_o = cfg_q.m_fiom;
    assign s_fiom_o = cfg_q.s_fiom;
endmodule

// File: rtl/envcfg_unit_chk.sv
module envcfg_unit_chk
    import envcfg_pkg::*;
#(
    parameter bit HAS_TC  = 1'b1,
    parameter bit FIOM_WR = 1'b1
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] csr_addr_i,
    input logic [CFG_W-1:0]  csr_wdata_i,
    input logic              csr_we_i,
    input logic              xlen32_i,
    input logic [CFG_W-1:0]  csr_rdata_o,
    input logic              tce_o,
    input logic              m_fiom_o,
    input logic              s_fiom_o
);
    assert_rsvd_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_addr_i == A_MCFG && !xlen32_i) |-> (csr_rdata_o[62:1] == '0));

    assert_tc_absent_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !HAS_TC |-> !tce_o);

    assert_fiom_locked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !FIOM_WR |-> (!m_fiom_o && !s_fiom_o));

    assert_sup_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_we_i && csr_addr_i == A_SCFG && FIOM_WR) |=> (s_fiom_o == $past(csr_wdata_i[0])));

    assert_low_half_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_we_i && xlen32_i && csr_addr_i == A_MCFG) |=> $stable(tce_o));

    assert_high_half_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_we_i && xlen32_i && csr_addr_i == A_MCFG_H) |=> $stable(m_fiom_o));

    assert_hi_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!xlen32_i && csr_addr_i == A_MCFG_H) |-> (csr_rdata_o == '0));

    assert_no_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !csr_we_i |=> ($stable(tce_o) && $stable(m_fiom_o) && $stable(s_fiom_o)));
endmodule

bind envcfg_unit envcfg_unit_chk #(.HAS_TC(HAS_TC), .FIOM_WR(FIOM_WR)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .csr_addr_i  (csr_addr_i),
    .csr_wdata_i (csr_wdata_i),
    .csr_we_i    (csr_we_i),
    .xlen32_i    (xlen32_i),
    .csr_rdata_o (csr_rdata_o),
    .tce_o       (tce_o),
    .m_fiom_o    (m_fiom_o),
    .s_fiom_o    (s_fiom_o)
);

// File: tb/envcfg_unit_tb_top.sv
module envcfg_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic [63:0] wdata = '0;
    logic        we = 1'b0;
    logic        x32 = 1'b0;
    logic [63:0] rd_on, rd_off;
    logic        tce_on, mf_on, sf_on, tce_off, mf_off, sf_off;
    int total = 0;
    int bad = 0;

    localparam logic [63:0] ONES = '1;

    always #2 clk = ~clk;

    envcfg_unit #(.HAS_TC(1'b1), .FIOM_WR(1'b1)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .csr_addr_i(addr), .csr_wdata_i(wdata),
        .csr_we_i(we), .xlen32_i(x32), .csr_rdata_o(rd_on),
        .tce_o(tce_on), .m_fiom_o(mf_on), .s_fiom_o(sf_on));

    envcfg_unit #(.HAS_TC(1'b0), .FIOM_WR(1'b0)) dut_off_i (
        .clk_i(clk), .rst_ni(rst_n), .csr_addr_i(addr), .csr_wdata_i(wdata),
        .csr_we_i(we), .xlen32_i(x32), .csr_rdata_o(rd_off),
        .tce_o(tce_off), .m_fiom_o(mf_off), .s_fiom_o(sf_off));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d, input logic m32, input logic en);
        @(negedge clk);
        addr = a; wdata = d; x32 = m32; we = en;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, input logic m32, input string req,
                      input logic [63:0] e_on, input logic [63:0] e_off);
        addr = a; x32 = m32;
        #1;
        chk({req, " on"}, rd_on, e_on);
        chk({req, " off"}, rd_off, e_off);
    endtask

    task automatic t_reset;
        rd(12'h30A, 1'b0, "R1 mcfg", 64'h0, 64'h0);
        rd(12'h10A, 1'b0, "R1 scfg", 64'h0, 64'h0);
        rd(12'h31A, 1'b1, "R1 mcfgh", 64'h0, 64'h0);
        chk("R1 outs", {61'h0, tce_on, mf_on, sf_on, tce_off, mf_off, sf_off}, 64'h0);
    endtask

    task automatic t_m64;
        wr(12'h30A, ONES, 1'b0, 1'b1);
        rd(12'h30A, 1'b0, "R2 R3 R4 mcfg ones", 64'h8000_0000_0000_0001, 64'h0);
        chk("R8 tce/mfiom on", {62'h0, tce_on, mf_on}, 64'h3);
        chk("R3 R4 tce/mfiom off", {62'h0, tce_off, mf_off}, 64'h0);
    endtask

    task automatic t_sup;
        wr(12'h10A, ONES, 1'b0, 1'b1);
        rd(12'h10A, 1'b0, "R5 R4 scfg ones", 64'h1, 64'h0);
        chk("R8 sfiom", {62'h0, sf_on, sf_off}, 64'h2);
    endtask

    task automatic t_hi64;
        rd(12'h31A, 1'b0, "R7 hi read", 64'h0, 64'h0);
        wr(12'h31A, 64'h0, 1'b0, 1'b1);
        rd(12'h30A, 1'b0, "R7 hi write ignored", 64'h8000_0000_0000_0001, 64'h0);
    endtask

    task automatic t_m32;
        wr(12'h30A, 64'h0, 1'b1, 1'b1);
        rd(12'h30A, 1'b1, "R6 low cleared", 64'h0, 64'h0);
        rd(12'h31A, 1'b1, "R6 high kept", 64'h8000_0000, 64'h0);
        chk("R6 R8 tce kept", {63'h0, tce_on}, 64'h1);
        wr(12'h31A, 64'h0, 1'b1, 1'b1);
        wr(12'h30A, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1);
        rd(12'h30A, 1'b1, "R6 low set zero-ext", 64'h1, 64'h0);
        rd(12'h31A, 1'b1, "R6 high cleared", 64'h0, 64'h0);
        rd(12'h30A, 1'b0, "R6 64-bit view", 64'h1, 64'h0);
        wr(12'h31A, 64'h8000_0000, 1'b1, 1'b1);
        rd(12'h30A, 1'b0, "R6 high set", 64'h8000_0000_0000_0001, 64'h0);
    endtask

    task automatic t_nowe;
        wr(12'h30A, 64'h0, 1'b0, 1'b0);
        wr(12'h10A, 64'h0, 1'b0, 1'b0);
        rd(12'h30A, 1'b0, "R10 mcfg held", 64'h8000_0000_0000_0001, 64'h0);
        rd(12'h10A, 1'b0, "R10 scfg held", 64'h1, 64'h0);
    endtask

    task automatic t_other;
        wr(12'h30B, 64'h0, 1'b0, 1'b1);
        wr(12'h11A, 64'h0, 1'b0, 1'b1);
        rd(12'h30B, 1'b0, "R9 read other", 64'h0, 64'h0);
        rd(12'h30A, 1'b0, "R9 mcfg untouched", 64'h8000_0000_0000_0001, 64'h0);
        rd(12'h10A, 1'b0, "R9 scfg untouched", 64'h1, 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_m64();
        t_sup();
        t_hi64();
        t_m32();
        t_nowe();
        t_other();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule